// File: doc/BRIEF.md
# Load/Store Queue Admission Credit Tracker

This block sits in the rename stage of an out-of-order, multithreaded core. It gates the load and store instructions that rename may send on. Each thread has two credit pools of its own, one for load-queue slots and one for store-queue slots. It also tracks how many loads and how many stores have left rename but have not yet been placed in their queues. The backend reports two things every cycle: how many slots each queue has free, and how many loads and stores it has just placed into the queues. The tracker subtracts the in-flight work from the free-slot report to find the credit that is really available.

Each cycle, rename offers an in-order group of up to W instructions from one thread. Each instruction is tagged as a load, a store or other. The tracker walks the group from oldest to youngest and uses up credit as it goes. It stops at the first load that finds no load credit, or the first store that finds no store credit. It reports how many instructions may proceed, and it counts each such blocking event by its cause. A separate stall flag is raised when neither kind of memory operation could be admitted for the thread. Stalls caused by the reorder buffer, the issue queue or the register free lists are merged in through one hold input.

Top module: `lsq_credit_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, every thread's loads-in-flight and stores-in-flight counts are set to zero. Its stored free-slot counts are loaded from `rpt_free_ld` and `rpt_free_st`, and both event counters are cleared.
- R2: Each load that proceeds adds one to its thread's loads-in-flight count. Each store that proceeds adds one to its thread's stores-in-flight count. Other instructions change neither count.
- R3: Each cycle, the per-thread dispatch counts `disp_ld` and `disp_st` are subtracted from the matching in-flight counts. A dispatch count larger than the in-flight count clamps that count to zero and raises `underflow_err` in the same cycle. Reporting enough dispatches, for example when the skid buffer is drained on a squash, returns the counts to zero and restores full credit.
- R4: Load credit is the effective free load count minus (loads in flight minus `disp_ld` this cycle). Store credit is formed the same way from the store values. The effective free count is the report itself in a cycle where that thread's `rpt_valid` bit is 1, and otherwise the stored count.
- R5: The group is scanned from slot 0 (oldest) upward, over the first `grp_cnt` slots. A load is blocked when the load credit left is zero or less, and a store is blocked when the store credit left is zero or less. `proceed_cnt` is the number of slots before the first blocked one.
- R6: Credit is used up cumulatively within a group: the k-th admitted load sees the load credit minus the k-1 loads admitted before it, and stores work the same way.
- R7: When the scan stops on a load, `ld_full_events` rises by one at the next edge. When it stops on a store, `st_full_events` rises by one. Neither counter changes in any other cycle.
- R8: `lsq_stall` is 1 exactly when both the load credit and the store credit of thread `ren_tid` are zero or less, evaluated before this group's consumption.
- R9: A thread's stored free counts take the reported values only at edges where that thread's `rpt_valid` bit is 1. At other edges they keep their previous values.
- R10: While `ext_stall` is 1, `proceed_cnt` is 0, no in-flight count grows, and no event is counted. Dispatch subtraction still takes place.
- R11: Admission for thread `ren_tid` leaves the in-flight counts and credits of every other thread unchanged.
- R12: Slot i of the group is `grp_kind[2i+1:2i]`, coded 2'b01 for a load and 2'b10 for a store. Both 2'b00 and 2'b11 mean other, and such an instruction is never blocked by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_stall | input | 1 | Stall from other rename resources; admits nothing |
| ren_tid | input | TIDW | Thread that owns this cycle's group |
| grp_cnt | input | PCW | Number of valid slots in the group (0..W) |
| grp_kind | input | 2*W | Per-slot kind code, slot 0 oldest |
| rpt_valid | input | NT | Per-thread flag that the free-slot report is valid |
| rpt_free_ld | input | NT*CW | Per-thread free load-queue slots (capacity-occupied-1) |
| rpt_free_st | input | NT*CW | Per-thread free store-queue slots (capacity-occupied-1) |
| disp_ld | input | NT*DW | Per-thread loads placed into the load queue this cycle |
| disp_st | input | NT*DW | Per-thread stores placed into the store queue this cycle |
| proceed_cnt | output | PCW | Number of oldest slots allowed to proceed |
| lsq_stall | output | 1 | Neither load nor store credit left for `ren_tid` |
| underflow_err | output | 1 | A dispatch count exceeded an in-flight count |
| ld_full_events | output | EW | Count of scans stopped by a load |
| st_full_events | output | EW | Count of scans stopped by a store |

## Verification
The bench builds the block with two threads, a group width of four and 5-bit credit counters. These values are small enough that a single group can use up a thread's whole load credit with slots left over. They also let one thread sit at zero credit while the other still admits instructions. With these settings, the cases of a store blocking after an admitted load, a dispatch count larger than the in-flight count, and a fresh valid report arriving in the same cycle as dispatches can all be reached in a dozen directed cycles.

// File: rtl/lsqc_pkg.sv
`timescale 1ns/1ps
// Package: shared kind codes for the load/store credit tracker.
// Assumes two bits per instruction slot in the rename group.
package lsqc_pkg;
    typedef enum logic [1:0] {
        KIND_OTHER = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_RSVD  = 2'b11
    } slot_kind_e;
endpackage

// File: rtl/lsqc_pool.sv
`timescale 1ns/1ps
// Module: lsqc_pool
// One credit pool (load or store) of one thread. It holds the last valid
// free-slot report and the count of operations in flight between rename
// and the queue, and it presents the signed credit available this cycle.
// Assumes CW >= DW and CW >= AW.
module lsqc_pool #(
    parameter int CW = 5,
    parameter int DW = 3,
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rpt_valid,
    input  logic [CW-1:0]        rpt_free,
    input  logic [DW-1:0]        disp,
    input  logic [AW-1:0]        add_cnt,
    output logic signed [CW:0]   avail,
    output logic                 underflow
);
    logic [CW-1:0] free_q;
    logic [CW-1:0] inflight_q;
    logic [CW-1:0] eff_free;
    logic [CW-1:0] net;
    logic [CW-1:0] disp_x;
    logic [CW:0]   next_sum;

    // Credit arithmetic: effective free count minus clamped in-flight count.
    always_comb begin
        disp_x    = {{(CW-DW){1'b0}}, disp};
        eff_free  = rpt_valid ? rpt_free : free_q;
        underflow = disp_x > inflight_q;
        net       = underflow ? '0 : inflight_q - disp_x;
        avail     = $signed({1'b0, eff_free}) - $signed({1'b0, net});
        next_sum  = {1'b0, net} + {{(CW+1-AW){1'b0}}, add_cnt};
    end

    // State update: reset loads the report, else refresh on valid and track flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_q     <= rpt_free;
            inflight_q <= '0;
        end else begin
            if (rpt_valid) free_q <= rpt_free;
            inflight_q <= next_sum[CW-1:0];
        end
    end

    // R2: the in-flight count must never wrap when admissions are added.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        next_sum[CW] == 1'b0);
endmodule

// File: rtl/lsqc_scan.sv
`timescale 1ns/1ps
// Module: lsqc_scan
// Walks one rename group from oldest slot upward, using up load and
// store credit cumulatively, and stops at the first memory operation
// that finds no credit. Purely combinational.
module lsqc_scan
    import lsqc_pkg::*;
#(
    parameter int W   = 4,
    parameter int AW  = 6,
    parameter int PCW = 3
) (
    input  logic                 hold,
    input  logic [PCW-1:0]       grp_cnt,
    input  logic [2*W-1:0]       grp_kind,
    input  logic signed [AW-1:0] avail_ld,
    input  logic signed [AW-1:0] avail_st,
    output logic [PCW-1:0]       proceed,
    output logic [PCW-1:0]       ld_taken,
    output logic [PCW-1:0]       st_taken,
    output logic                 ld_block,
    output logic                 st_block
);
    localparam logic signed [AW-1:0] ONE = AW'(1);

    logic signed [AW-1:0] ld_left;
    logic signed [AW-1:0] st_left;
    logic                 stopped;
    slot_kind_e           kind;

    // In-order scan with cumulative credit consumption.
    always_comb begin
        ld_left  = avail_ld;
        st_left  = avail_st;
        stopped  = hold;
        proceed  = '0;
        ld_taken = '0;
        st_taken = '0;
        ld_block = 1'b0;
        st_block = 1'b0;
        kind     = KIND_OTHER;
        for (int i = 0; i < W; i++) begin
            if (!stopped && (PCW'(i) < grp_cnt)) begin
                kind = slot_kind_e'(grp_kind[2*i +: 2]);
                if (kind == KIND_LOAD && ld_left <= 0) begin
                    stopped  = 1'b1;
                    ld_block = 1'b1;
                end else if (kind == KIND_STORE && st_left <= 0) begin
                    stopped  = 1'b1;
                    st_block = 1'b1;
                end else begin
                    proceed = proceed + 1'b1;
                    if (kind == KIND_LOAD) begin
                        ld_left  = ld_left - ONE;
                        ld_taken = ld_taken + 1'b1;
                    end
                    if (kind == KIND_STORE) begin
                        st_left  = st_left - ONE;
                        st_taken = st_taken + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lsq_credit_gate.sv
`timescale 1ns/1ps
// Module: lsq_credit_gate
// Top of the load/store admission credit tracker. One load pool and one
// store pool per thread, one scanner for the thread renaming this cycle,
// and two event counters for scans stopped by a load or by a store.
// Assumes one thread owns the rename group in a given cycle.
module lsq_credit_gate #(
    parameter int NT   = 2,
    parameter int W    = 4,
    parameter int CW   = 5,
    parameter int DW   = 3,
    parameter int EW   = 8,
    parameter int TIDW = (NT > 1) ? $clog2(NT) : 1,
    parameter int PCW  = $clog2(W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_stall,
    input  logic [TIDW-1:0]      ren_tid,
    input  logic [PCW-1:0]       grp_cnt,
    input  logic [2*W-1:0]       grp_kind,
    input  logic [NT-1:0]        rpt_valid,
    input  logic [NT*CW-1:0]     rpt_free_ld,
    input  logic [NT*CW-1:0]     rpt_free_st,
    input  logic [NT*DW-1:0]     disp_ld,
    input  logic [NT*DW-1:0]     disp_st,
    output logic [PCW-1:0]       proceed_cnt,
    output logic                 lsq_stall,
    output logic                 underflow_err,
    output logic [EW-1:0]        ld_full_events,
    output logic [EW-1:0]        st_full_events
);
    localparam int AW = CW + 1;

    logic signed [AW-1:0] av_ld [NT];
    logic signed [AW-1:0] av_st [NT];
    logic [NT-1:0]        uf_ld;
    logic [NT-1:0]        uf_st;
    logic [PCW-1:0]       ld_taken, st_taken;
    logic                 ld_block, st_block;
    logic signed [AW-1:0] sel_ld, sel_st;
    logic [EW-1:0]        ld_ev_q, st_ev_q;

    // Per-thread load and store pools.
    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic hit;
        assign hit = (ren_tid == TIDW'(t));
        lsqc_pool #(.CW(CW), .DW(DW), .AW(PCW)) u_ld (
            .clk(clk), .rst_n(rst_n),
            .rpt_valid(rpt_valid[t]),
            .rpt_free(rpt_free_ld[t*CW +: CW]),
            .disp(disp_ld[t*DW +: DW]),
            .add_cnt(hit ? ld_taken : '0),
            .avail(av_ld[t]),
            .underflow(uf_ld[t])
        );
        lsqc_pool #(.CW(CW), .DW(DW), .AW(PCW)) u_st (
            .clk(clk), .rst_n(rst_n),
            .rpt_valid(rpt_valid[t]),
            .rpt_free(rpt_free_st[t*CW +: CW]),
            .disp(disp_st[t*DW +: DW]),
            .add_cnt(hit ? st_taken : '0),
            .avail(av_st[t]),
            .underflow(uf_st[t])
        );
    end

    // Select the renaming thread's credit and form the stall and error flags.
    always_comb begin
        sel_ld        = av_ld[ren_tid];
        sel_st        = av_st[ren_tid];
        lsq_stall     = (sel_ld <= 0) && (sel_st <= 0);
        underflow_err = |{uf_ld, uf_st};
    end

    lsqc_scan #(.W(W), .AW(AW), .PCW(PCW)) u_scan (
        .hold(ext_stall),
        .grp_cnt(grp_cnt),
        .grp_kind(grp_kind),
        .avail_ld(sel_ld),
        .avail_st(sel_st),
        .proceed(proceed_cnt),
        .ld_taken(ld_taken),
        .st_taken(st_taken),
        .ld_block(ld_block),
        .st_block(st_block)
    );

    // Full-event counters, one per blocking cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_ev_q <= '0;
            st_ev_q <= '0;
        end else begin
            if (ld_block) ld_ev_q <= ld_ev_q + 1'b1;
            if (st_block) st_ev_q <= st_ev_q + 1'b1;
        end
    end

    assign ld_full_events = ld_ev_q;
    assign st_full_events = st_ev_q;

    // R6: loads admitted never exceed the positive part of the load credit.
    assert_taken_in_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_taken == '0) || ($signed({1'b0, ld_taken}) <= sel_ld));
    // R5: a blocking event means not every valid slot proceeded.
    assert_stop_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_block || st_block) |-> (proceed_cnt < grp_cnt));
    // R8: with the stall flag up, a leading memory operation cannot proceed.
    assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsq_stall && grp_cnt != '0 && (grp_kind[1:0] == 2'b01 || grp_kind[1:0] == 2'b10))
        |-> (proceed_cnt == '0));
    // R10: a held cycle admits nothing and leaves the event counters alone.
    assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stall |=> (ld_full_events == $past(ld_full_events)) &&
                      (st_full_events == $past(st_full_events)));
    // R7: the load event counter moves by at most one per cycle.
    assert_event_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_full_events != $past(ld_full_events)) |->
        (ld_full_events == $past(ld_full_events) + 1'b1));
endmodule

// File: tb/lsq_credit_gate_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: step() drives one cycle, models the expected outputs
// from the requirements and queues them; the monitor compares.
module lsq_credit_gate_tb;
    localparam int NT = 2, W = 4, CW = 5, DW = 3, EW = 8, TIDW = 1, PCW = 3;

    typedef struct {
        int    proceed;
        bit    stall;
        bit    err;
        int    ldev;
        int    stev;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_stall = 1'b0;
    logic [TIDW-1:0] ren_tid = '0;
    logic [PCW-1:0] grp_cnt = '0;
    logic [2*W-1:0] grp_kind = '0;
    logic [NT-1:0] rpt_valid = '0;
    logic [NT*CW-1:0] rpt_free_ld = '0, rpt_free_st = '0;
    logic [NT*DW-1:0] disp_ld = '0, disp_st = '0;
    logic [PCW-1:0] proceed_cnt;
    logic lsq_stall, underflow_err;
    logic [EW-1:0] ld_full_events, st_full_events;

    lsq_credit_gate #(.NT(NT), .W(W), .CW(CW), .DW(DW), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_stall(ext_stall), .ren_tid(ren_tid),
        .grp_cnt(grp_cnt), .grp_kind(grp_kind), .rpt_valid(rpt_valid),
        .rpt_free_ld(rpt_free_ld), .rpt_free_st(rpt_free_st),
        .disp_ld(disp_ld), .disp_st(disp_st), .proceed_cnt(proceed_cnt),
        .lsq_stall(lsq_stall), .underflow_err(underflow_err),
        .ld_full_events(ld_full_events), .st_full_events(st_full_events)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    exp_t sb[$];

    // bench-side stimulus and model state
    int b_tid, b_cnt, b_ext;
    int b_kind[W];
    int b_rv[NT], b_rfl[NT], b_rfs[NT], b_dl[NT], b_ds[NT];
    int m_fl[NT], m_fs[NT], m_il[NT], m_is[NT];
    int m_ldev = 0, m_stev = 0;

    task automatic clear_stim();
        b_ext = 0; b_cnt = 0;
        for (int i = 0; i < W; i++) b_kind[i] = 0;
        for (int t = 0; t < NT; t++) begin
            b_rv[t] = 0; b_dl[t] = 0; b_ds[t] = 0;
        end
    endtask

    task automatic step(input string tag);
        int efl[NT], efs[NT], nl[NT], ns[NT], al[NT], as_[NT];
        int ll, sl, pr, tl, ts;
        bit er, lb, sb_, stop;
        exp_t e;
        @(negedge clk);
        ext_stall = b_ext[0];
        ren_tid   = TIDW'(b_tid);
        grp_cnt   = PCW'(b_cnt);
        for (int i = 0; i < W; i++) grp_kind[2*i +: 2] = 2'(b_kind[i]);
        for (int t = 0; t < NT; t++) begin
            rpt_valid[t] = b_rv[t][0];
            rpt_free_ld[t*CW +: CW] = CW'(b_rfl[t]);
            rpt_free_st[t*CW +: CW] = CW'(b_rfs[t]);
            disp_ld[t*DW +: DW] = DW'(b_dl[t]);
            disp_st[t*DW +: DW] = DW'(b_ds[t]);
        end
        er = 0;
        for (int t = 0; t < NT; t++) begin
            efl[t] = b_rv[t] != 0 ? b_rfl[t] : m_fl[t];
            efs[t] = b_rv[t] != 0 ? b_rfs[t] : m_fs[t];
            nl[t] = m_il[t] - b_dl[t];
            ns[t] = m_is[t] - b_ds[t];
            if (nl[t] < 0) begin er = 1; nl[t] = 0; end
            if (ns[t] < 0) begin er = 1; ns[t] = 0; end
            al[t] = efl[t] - nl[t];
            as_[t] = efs[t] - ns[t];
        end
        ll = al[b_tid]; sl = as_[b_tid];
        pr = 0; tl = 0; ts = 0; lb = 0; sb_ = 0; stop = (b_ext != 0);
        for (int i = 0; i < W; i++) begin
            if (!stop && i < b_cnt) begin
                if (b_kind[i] == 1 && ll <= 0) begin stop = 1; lb = 1; end
                else if (b_kind[i] == 2 && sl <= 0) begin stop = 1; sb_ = 1; end
                else begin
                    pr++;
                    if (b_kind[i] == 1) begin ll--; tl++; end
                    if (b_kind[i] == 2) begin sl--; ts++; end
                end
            end
        end
        e.proceed = pr;
        e.stall = (al[b_tid] <= 0) && (as_[b_tid] <= 0);
        e.err = er;
        e.ldev = m_ldev;
        e.stev = m_stev;
        e.tag = tag;
        sb.push_back(e);
        for (int t = 0; t < NT; t++) begin
            m_fl[t] = efl[t]; m_fs[t] = efs[t];
            m_il[t] = nl[t] + (t == b_tid ? tl : 0);
            m_is[t] = ns[t] + (t == b_tid ? ts : 0);
        end
        m_ldev = (m_ldev + lb) % 256;
        m_stev = (m_stev + sb_) % 256;
    endtask

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops each expected item and compares just before the edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "proceed_cnt", int'(proceed_cnt), e.proceed);
                cmp(e.tag, "lsq_stall", int'(lsq_stall), int'(e.stall));
                cmp(e.tag, "underflow_err", int'(underflow_err), int'(e.err));
                cmp(e.tag, "ld_full_events", int'(ld_full_events), e.ldev);
                cmp(e.tag, "st_full_events", int'(st_full_events), e.stev);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #20000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clear_stim();
        b_tid = 0;
        b_rfl[0] = 3; b_rfs[0] = 2; b_rfl[1] = 2; b_rfs[1] = 2;
        for (int t = 0; t < NT; t++) begin
            rpt_free_ld[t*CW +: CW] = CW'(b_rfl[t]);
            rpt_free_st[t*CW +: CW] = CW'(b_rfs[t]);
            m_fl[t] = b_rfl[t]; m_fs[t] = b_rfs[t]; m_il[t] = 0; m_is[t] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty group right after reset, counters zero
        step("R1_reset");
        // R5 R6: four loads against three credits
        clear_stim(); b_cnt = 4; for (int i = 0; i < 4; i++) b_kind[i] = 1;
        step("R5_R6_loads");
        // R7 R2: stores exhaust store credit on the third
        clear_stim(); b_cnt = 4; b_kind[0] = 2; b_kind[1] = 2; b_kind[2] = 2;
        step("R7_R2_stores");
        // R8: both pools empty; other passes, load blocks
        clear_stim(); b_cnt = 2; b_kind[1] = 1;
        step("R8_stall");
        // R3 R4: one load dispatched frees one credit this cycle
        clear_stim(); b_dl[0] = 1; b_cnt = 2; b_kind[0] = 1; b_kind[1] = 1;
        step("R3_R4_dispatch");
        // R9 R4: fresh valid report with dispatches, mixed group
        clear_stim(); b_rv[0] = 1; b_rfl[0] = 6; b_rfs[0] = 3; b_dl[0] = 3; b_ds[0] = 2;
        b_cnt = 4; b_kind[0] = 1; b_kind[1] = 2; b_kind[2] = 1; b_kind[3] = 2;
        step("R9_R4_report");
        // R9: report not valid; changed values ignored
        clear_stim(); b_rfl[0] = 0; b_rfs[0] = 0; b_cnt = 4;
        for (int i = 0; i < 4; i++) b_kind[i] = 1;
        step("R9_hold_report");
        // R10: held group admits nothing
        clear_stim(); b_ext = 1; b_cnt = 4; for (int i = 0; i < 4; i++) b_kind[i] = 2;
        step("R10_hold");
        // R10: stores after hold still see same credit
        clear_stim(); b_cnt = 2; b_kind[0] = 2; b_kind[1] = 2;
        step("R10_after");
        // R11: thread 1 unaffected by thread 0 use
        clear_stim(); b_tid = 1; b_cnt = 4; b_kind[0] = 1; b_kind[1] = 1; b_kind[2] = 2; b_kind[3] = 2;
        step("R11_thread1");
        // R3: over-dispatch raises error and clamps
        clear_stim(); b_tid = 1; b_dl[1] = 5;
        step("R3_underflow");
        // R12: code 3 and 0 are other, interleaved with memory ops
        clear_stim(); b_tid = 1; b_cnt = 4; b_kind[0] = 3; b_kind[1] = 1; b_kind[2] = 0; b_kind[3] = 2;
        step("R12_kinds");
        // R3: squash drain returns thread 0 counts to zero
        clear_stim(); b_tid = 0; b_dl[0] = m_il[0]; b_ds[0] = m_is[0];
        step("R3_drain");
        // R11 R5: thread 0 full credit again after drain
        clear_stim(); b_tid = 0; b_cnt = 4; b_kind[0] = 1; b_kind[1] = 2; b_kind[2] = 1; b_kind[3] = 1;
        step("R5_R11_refill");
        clear_stim();
        step("R7_final_counts");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule